// File: doc/BRIEF.md
# Wrapping Four-Beat Column Burst Address Generator

This block supplies column addresses for a burst-oriented DRAM interface. A controller gives it one external column address and pulses a start strobe. The block then produces the four column addresses of the burst by itself, so the controller does not supply a new address for each beat. Only the two low column bits change during a burst. They wrap inside the aligned group of four, and the upper bits stay at the value that was captured.

The address leaves the block through a registered output stage. A second register always holds the address for the following beat, so the next address is ready while the current beat is still on the outputs. The outgoing address stream uses a valid/ready pair. `addr_valid` is high while a burst is active. The consumer raises `addr_ready` to accept the beat that is currently shown. While `addr_ready` is low, the address and beat index hold their values. Ready has no effect while no burst is active. `start` is a plain control strobe, is not subject to back-pressure, and overrides any beat accepted in the same cycle.

Top module: `colburst_agen`

## Requirements
- R1: After reset, `addr_valid` and `last_beat` are 0, and `burst_addr` and `beat_idx` are 0.
- R2: In the cycle after `start` is sampled high, `addr_valid` is 1, `beat_idx` is 0 and `burst_addr` equals the `col_in` value sampled with `start`.
- R3: Each accepted beat (`addr_valid` and `addr_ready` high, `start` low) that is not the fourth beat adds 1 modulo 4 to `burst_addr[1:0]` and adds 1 to `beat_idx` in the next cycle. `burst_addr[COL_W-1:2]` never changes during a burst.
- R4: The low two bits wrap inside the aligned group of four: a start offset of 2 gives 2, 3, 0, 1, and a start offset of 3 gives 3, 0, 1, 2.
- R5: A burst has exactly four beats. After the beat with `beat_idx` = 3 is accepted, `addr_valid` is 0 in the next cycle.
- R6: `last_beat` is 1 exactly when `addr_valid` is 1 and `beat_idx` is 3.
- R7: While `addr_valid` is 1 and `addr_ready` and `start` are 0, `burst_addr` and `beat_idx` hold their values in the next cycle.
- R8: `start` during an active burst abandons that burst and begins a new one from the new `col_in`. This holds even when a beat, including the fourth, is accepted in the same cycle.
- R9: While no burst is active, `addr_ready` has no effect: `addr_valid` stays 0 and `burst_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture `col_in` and begin a burst |
| col_in | input | COL_W | External column address |
| addr_ready | input | 1 | Consumer accepts the current beat |
| burst_addr | output | COL_W | Current internal column address |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |
| addr_valid | output | 1 | Burst active; `burst_addr` is valid |
| last_beat | output | 1 | Current beat is the fourth |

## Verification
Two functions can fall in the same cycle: a fresh `start` and the acceptance of a beat of the running burst. The hardest case is acceptance of the fourth beat, which would otherwise end the burst. The bench provokes this by pulsing `start` with `addr_ready` high, once in the middle of a burst and once on its last beat. It expects the next cycle to show the new address at beat 0 with `addr_valid` still high, and no increment and no end of burst.

// File: rtl/colburst_pkg.sv
package colburst_pkg;
  // log2 of the burst length; the wrap group is 2**BURST_LOG2 locations
  parameter int unsigned BURST_LOG2 = 2;
  localparam int unsigned BURST_LEN = 1 << BURST_LOG2;

  typedef logic [BURST_LOG2-1:0] beat_t;

  function automatic beat_t beat_inc(beat_t v);
    return beat_t'(v + beat_t'(1));
  endfunction
endpackage

// File: rtl/colburst_wrapctr.sv
module colburst_wrapctr
  import colburst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t load_val,
  input  logic  step,
  output beat_t cur
);
  beat_t cur_q, nxt_q;

  // nxt_q always holds the offset of the following beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      nxt_q <= beat_t'(1);
    end else if (load) begin
      cur_q <= load_val;
      nxt_q <= beat_inc(load_val);
    end else if (step) begin
      cur_q <= nxt_q;
      nxt_q <= beat_inc(nxt_q);
    end
  end

  assign cur = cur_q;

  // R3
  step_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> cur == beat_inc($past(cur)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cur));
endmodule

// File: rtl/colburst_beattrk.sv
module colburst_beattrk
  import colburst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  accept,
  output beat_t beat,
  output logic  active,
  output logic  last
);
  localparam beat_t LAST_IDX = beat_t'(BURST_LEN - 1);

  beat_t beat_q;
  logic  active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      beat_q   <= '0;
      active_q <= 1'b1;
    end else if (accept && active_q) begin
      if (beat_q == LAST_IDX) active_q <= 1'b0;
      else                    beat_q   <= beat_inc(beat_q);
    end
  end

  assign beat   = beat_q;
  assign active = active_q;
  assign last   = active_q && (beat_q == LAST_IDX);

  // R5
  burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last && !start) |=> !active);

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && beat == '0));
endmodule

// File: rtl/colburst_agen.sv
module colburst_agen
  import colburst_pkg::*;
#(
  parameter int unsigned COL_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [COL_W-1:0]      col_in,
  input  logic                  addr_ready,
  output logic [COL_W-1:0]      burst_addr,
  output logic [BURST_LOG2-1:0] beat_idx,
  output logic                  addr_valid,
  output logic                  last_beat
);
  localparam int unsigned HI_W = COL_W - BURST_LOG2;

  logic [HI_W-1:0] base_q;
  beat_t           off;
  beat_t           beat;
  logic            active, last;
  logic            accept, step;

  // start wins over a beat handshake in the same cycle
  assign accept = active && addr_ready && !start;
  // the fourth beat ends the burst without moving the address
  assign step   = accept && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (start) base_q <= col_in[COL_W-1:BURST_LOG2];
  end

  colburst_wrapctr u_wrap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (col_in[BURST_LOG2-1:0]),
    .step     (step),
    .cur      (off)
  );

  colburst_beattrk u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .beat   (beat),
    .active (active),
    .last   (last)
  );

  assign burst_addr = {base_q, off};
  assign beat_idx   = beat;
  assign addr_valid = active;
  assign last_beat  = last;

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> burst_addr == $past(col_in));

  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !start) |=> $stable(burst_addr[COL_W-1:BURST_LOG2]));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !start) |=> ($stable(burst_addr) && $stable(beat_idx)));

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !start) |=> (!addr_valid && $stable(burst_addr)));

  // R6
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> (addr_valid && beat_idx == BURST_LOG2'(BURST_LEN - 1)));
endmodule

// File: tb/test_colburst_agen.sv
module test_colburst_agen;
  localparam int COL_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] col_in = '0;
  logic             addr_ready = 1'b0;
  logic [COL_W-1:0] burst_addr;
  logic [1:0]       beat_idx;
  logic             addr_valid;
  logic             last_beat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  colburst_agen #(.COL_W(COL_W)) i_colburst_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .col_in(col_in),
    .addr_ready(addr_ready), .burst_addr(burst_addr), .beat_idx(beat_idx),
    .addr_valid(addr_valid), .last_beat(last_beat)
  );

  // scoreboard queues
  bit    qv[$];
  int    qa[$];
  int    qb[$];
  bit    ql[$];
  string qt[$];

  // reference model state derived from the requirements
  bit m_valid = 0;
  int m_base = 0;
  int m_off = 0;
  int m_beat = 0;

  task automatic step_cyc(input bit st, input int col, input bit rdy, input string tag);
    @(negedge clk);
    start = st; col_in = COL_W'(col); addr_ready = rdy;
    if (st) begin
      m_valid = 1; m_base = col & ~3; m_off = col & 3; m_beat = 0;
    end else if (m_valid && rdy) begin
      if (m_beat == 3) m_valid = 0;
      else begin m_beat++; m_off = (m_off + 1) & 3; end
    end
    qv.push_back(m_valid);
    qa.push_back(m_base | m_off);
    qb.push_back(m_beat);
    ql.push_back(m_valid && m_beat == 3);
    qt.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (qv.size() > 0) begin
      bit ev, el; int ea, eb; string t;
      ev = qv.pop_front(); ea = qa.pop_front(); eb = qb.pop_front();
      el = ql.pop_front(); t = qt.pop_front();
      checks++;
      if (addr_valid !== ev || int'(burst_addr) != ea || last_beat !== el ||
          (ev && int'(beat_idx) != eb)) begin
        errors++;
        $display("FAIL %s: actual v=%0b a=%h b=%0d l=%0b expected v=%0b a=%h b=%0d l=%0b",
                 t, addr_valid, burst_addr, beat_idx, last_beat, ev, ea, eb, el);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if (addr_valid !== 1'b0 || last_beat !== 1'b0 || burst_addr !== '0 || beat_idx !== 2'd0) begin
      errors++;
      $display("FAIL R1: actual v=%0b l=%0b a=%h b=%0d expected 0 0 0 0",
               addr_valid, last_beat, burst_addr, beat_idx);
    end
    rst_n = 1'b1;
    // R9: ready while idle
    step_cyc(0, 12'h555, 1, "R9");
    step_cyc(0, 12'h555, 1, "R9");
    // R2/R4/R6/R5: offset 2 -> 2,3,0,1
    step_cyc(1, 12'h012, 0, "R2");
    step_cyc(0, 0, 1, "R4");
    step_cyc(0, 0, 1, "R4");
    step_cyc(0, 0, 1, "R6");
    step_cyc(0, 0, 1, "R5");
    step_cyc(0, 0, 1, "R9");
    // R7: stalls, upper bits fixed
    step_cyc(1, 12'h3FC, 1, "R2");
    step_cyc(0, 0, 0, "R7");
    step_cyc(0, 0, 0, "R7");
    step_cyc(0, 0, 1, "R3");
    step_cyc(0, 0, 0, "R7");
    step_cyc(0, 0, 1, "R3");
    step_cyc(0, 0, 1, "R6");
    step_cyc(0, 0, 0, "R7");
    step_cyc(0, 0, 1, "R5");
    // R4: offset 3 -> 3,0,1,2
    step_cyc(1, 12'hAB7, 1, "R2");
    step_cyc(0, 0, 1, "R4");
    step_cyc(0, 0, 1, "R3");
    step_cyc(0, 0, 1, "R6");
    // R8: restart on the last-beat acceptance
    step_cyc(1, 12'h0C1, 1, "R8");
    step_cyc(0, 0, 1, "R3");
    // R8: restart mid-burst with ready high
    step_cyc(1, 12'hF0E, 1, "R8");
    step_cyc(0, 0, 1, "R4");
    step_cyc(0, 0, 1, "R4");
    step_cyc(0, 0, 1, "R6");
    step_cyc(0, 0, 1, "R5");
    step_cyc(0, 0, 0, "R9");
    @(negedge clk); start = 0; addr_ready = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule